// File: doc/BRIEF.md
# Packed Sub-Word Integer SIMD ALU

This block is an integer arithmetic unit that treats two 64-bit operands as packed vectors. Each operation chooses its own lane size: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. The datapath is cut at every lane edge, so no carry or borrow passes from one element into the next, and each lane computes on its own.

The operations are:

- Add and subtract, each in three forms: wrap-around, signed clamping and unsigned clamping.
- Signed and unsigned minimum and maximum.
- Three compares. Each compare writes an element mask: all-ones where the condition holds and zero where it fails.
- A horizontal sum of absolute differences. It reduces the eight byte lanes of both operands to a single small count.

The unit holds no programmable state and raises no exceptions. Every request is one operation plus two operands. The answer appears one clock later, together with a valid flag. The output register keeps the last answer until a new request arrives.

Top module: `simd_alu`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` equals the `in_valid` of the previous cycle. `result` shows the answer to the operands accepted one edge earlier. On cycles with no request, `result` keeps its value.
- R3: Lane size is set by `width`:
  - 0 gives eight 8-bit lanes.
  - 1 gives four 16-bit lanes.
  - 2 or 3 gives two 32-bit lanes.

  Lane k occupies bits [k*L+L-1 : k*L]. No carry or borrow crosses a lane edge.
- R4: Op 0 (add) and op 3 (subtract, a minus b) wrap each lane modulo 2^L.
- R5: Op 1 (add) and op 4 (subtract) clamp each lane to the signed range [-2^(L-1), 2^(L-1)-1] on overflow.
- R6: Op 2 (add) and op 5 (subtract) clamp each lane to the unsigned range: all-ones on overflow, zero on underflow.
- R7: Lane-wise selection, with ties returning either operand's equal value:

  | Op | Result |
  |----|--------|
  | 6 | signed minimum |
  | 7 | unsigned minimum |
  | 8 | signed maximum |
  | 9 | unsigned maximum |

- R8: Compares write all-ones into each lane where the condition holds and zero into the others:
  - Op 10: a equal to b.
  - Op 11: a greater than b, signed.
  - Op 12: a greater than b, unsigned.
- R9: Op 13 puts the sum over all eight unsigned bytes of |a_byte - b_byte| in `result[15:0]`. Bits 63:16 are zero, and `width` is ignored.
- R10: Op codes 14 and 15 are reserved. They produce an all-zero result that is still flagged valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A request is present this cycle |
| op | input | 4 | Operation code (see R4 to R10) |
| width | input | 2 | Lane size select (see R3) |
| a | input | 64 | First packed operand |
| b | input | 64 | Second packed operand |
| out_valid | output | 1 | `result` holds a new answer |
| result | output | 64 | Registered packed result |

## Verification
Two things can land in the same cycle: a lane that clamps and a neighbouring lane that wraps or stays in range. The bench provokes this with byte and halfword patterns in which the low lane overflows while the lane above it sits at its own limit. It then judges every lane against a reference model that works one element at a time. A carry leaking upward, or a clamp spilling into a neighbour, shows up as a wrong value in the adjacent lane. The same-cycle pairing of a valid result with a new request is covered by back-to-back streams, in which every output is matched to its request in order through the scoreboard queue.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int SAD_OUT_W = 16;

    typedef enum logic [1:0] {
        LW_8    = 2'd0,
        LW_16   = 2'd1,
        LW_32   = 2'd2,
        LW_32B  = 2'd3
    } lane_sel_e;

    typedef enum logic [3:0] {
        OP_ADD_WR = 4'd0,
        OP_ADD_SS = 4'd1,
        OP_ADD_US = 4'd2,
        OP_SUB_WR = 4'd3,
        OP_SUB_SS = 4'd4,
        OP_SUB_US = 4'd5,
        OP_MIN_S  = 4'd6,
        OP_MIN_U  = 4'd7,
        OP_MAX_S  = 4'd8,
        OP_MAX_U  = 4'd9,
        OP_CEQ    = 4'd10,
        OP_CGTS   = 4'd11,
        OP_CGTU   = 4'd12,
        OP_SAD    = 4'd13,
        OP_RSV0   = 4'd14,
        OP_RSV1   = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic        vld;
        logic [63:0] data;
    } alu_out_t;

    function automatic logic [7:0] byte_absdiff(input logic [7:0] x, input logic [7:0] y);
        return (x > y) ? (x - y) : (y - x);
    endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_pkg::*;
#(
    parameter int LW = 8
) (
    input  alu_op_e        op,
    input  logic [LW-1:0]  a,
    input  logic [LW-1:0]  b,
    output logic [LW-1:0]  r
);
    localparam logic [LW-1:0] S_MAX = {1'b0, {(LW-1){1'b1}}};
    localparam logic [LW-1:0] S_MIN = {1'b1, {(LW-1){1'b0}}};
    localparam logic [LW-1:0] ONES  = {LW{1'b1}};

    logic [LW:0] sum_x, dif_x;
    logic        add_sov, sub_sov, s_lt, u_lt, eq;

    always_comb begin
        sum_x   = {1'b0, a} + {1'b0, b};
        dif_x   = {1'b0, a} - {1'b0, b};
        add_sov = (a[LW-1] == b[LW-1]) && (sum_x[LW-1] != a[LW-1]);
        sub_sov = (a[LW-1] != b[LW-1]) && (dif_x[LW-1] != a[LW-1]);
        s_lt    = $signed(a) < $signed(b);
        u_lt    = a < b;
        eq      = (a == b);
    end

    always_comb begin
        unique case (op)
            OP_ADD_WR: r = sum_x[LW-1:0];
            OP_ADD_SS: r = add_sov ? (a[LW-1] ? S_MIN : S_MAX) : sum_x[LW-1:0];
            OP_ADD_US: r = sum_x[LW] ? ONES : sum_x[LW-1:0];
            OP_SUB_WR: r = dif_x[LW-1:0];
            OP_SUB_SS: r = sub_sov ? (a[LW-1] ? S_MIN : S_MAX) : dif_x[LW-1:0];
            OP_SUB_US: r = dif_x[LW] ? '0 : dif_x[LW-1:0];
            OP_MIN_S:  r = s_lt ? a : b;
            OP_MIN_U:  r = u_lt ? a : b;
            OP_MAX_S:  r = s_lt ? b : a;
            OP_MAX_U:  r = u_lt ? b : a;
            OP_CEQ:    r = eq ? ONES : '0;
            OP_CGTS:   r = (!s_lt && !eq) ? ONES : '0;
            OP_CGTU:   r = (!u_lt && !eq) ? ONES : '0;
            default:   r = '0;
        endcase
    end
endmodule

// File: rtl/simd_sad.sv
module simd_sad
    import simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]    a,
    input  logic [DATA_W-1:0]    b,
    output logic [SAD_OUT_W-1:0] sad
);
    localparam int NBYTES = DATA_W / 8;

    logic [SAD_OUT_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < NBYTES; i++) begin
            acc = acc + SAD_OUT_W'(byte_absdiff(a[i*8 +: 8], b[i*8 +: 8]));
        end
        sad = acc;
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [1:0]        width,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int NSIZES = 3;

    alu_op_e              op_e;
    lane_sel_e            sel_e;
    logic [DATA_W-1:0]    res_by_w [NSIZES];
    logic [SAD_OUT_W-1:0] sad_val;
    logic [DATA_W-1:0]    nxt;
    alu_out_t             out_q;

    assign op_e  = alu_op_e'(op);
    assign sel_e = lane_sel_e'(width);

    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        localparam int LW = 8 << g;
        localparam int NL = DATA_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            simd_lane #(.LW(LW)) u_lane (
                .op (op_e),
                .a  (a[l*LW +: LW]),
                .b  (b[l*LW +: LW]),
                .r  (res_by_w[g][l*LW +: LW])
            );
        end
    end

    simd_sad #(.DATA_W(DATA_W)) u_sad (
        .a   (a),
        .b   (b),
        .sad (sad_val)
    );

    always_comb begin
        if (op_e == OP_SAD) begin
            nxt = DATA_W'(sad_val);
        end else begin
            unique case (sel_e)
                LW_8:    nxt = res_by_w[0];
                LW_16:   nxt = res_by_w[1];
                default: nxt = res_by_w[2];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.vld <= in_valid;
            if (in_valid) begin
                out_q.data <= nxt;
            end
        end
    end

    assign out_valid = out_q.vld;
    assign result    = out_q.data;
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [3:0]        op,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);
    function automatic logic bytes_are_mask(input logic [DATA_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DATA_W / 8; i++) begin
            if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
        end
        return ok;
    endfunction

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && result == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R8
    cmp_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 4'd10 || op == 4'd11 || op == 4'd12)) |=> bytes_are_mask(result));

    // R9
    sad_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'd13) |=> (result[DATA_W-1:16] == '0));

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op >= 4'd14) |=> (result == '0));
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_simd_alu.sv
`timescale 1ns/1ps
module tb_simd_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  width = '0;
    logic [63:0] a = '0, b = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [63:0] last_exp = '0;
    longint unsigned rng = 64'h9E3779B97F4A7C15;

    always #2 clk = ~clk;

    simd_alu dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .width(width),
        .a(a), .b(b), .out_valid(out_valid), .result(result)
    );

    function automatic string tag_of(int o);
        if (o == 0 || o == 3) return "R4";
        if (o == 1 || o == 4) return "R5";
        if (o == 2 || o == 5) return "R6";
        if (o >= 6 && o <= 9) return "R7";
        if (o >= 10 && o <= 12) return "R8";
        if (o == 13) return "R9";
        return "R10";
    endfunction

    function automatic logic [63:0] model(int o, int w, logic [63:0] x, logic [63:0] y);
        int lw;
        longint m, half, ua, ub, sa, sb2, v;
        logic [63:0] r;
        r = '0;
        if (o == 13) begin
            longint s = 0;
            for (int i = 0; i < 8; i++) begin
                ua = longint'(x[i*8 +: 8]);
                ub = longint'(y[i*8 +: 8]);
                s += (ua > ub) ? ua - ub : ub - ua;
            end
            return 64'(s);
        end
        if (o >= 14) return '0;
        lw = (w == 0) ? 8 : (w == 1) ? 16 : 32;
        m = (longint'(1) << lw) - 1;
        half = longint'(1) << (lw - 1);
        for (int i = 0; i < 64 / lw; i++) begin
            ua = longint'((x >> (i * lw))) & m;
            ub = longint'((y >> (i * lw))) & m;
            sa = (ua >= half) ? ua - (m + 1) : ua;
            sb2 = (ub >= half) ? ub - (m + 1) : ub;
            case (o)
                0: v = ua + ub;
                1: begin v = sa + sb2; if (v > half - 1) v = half - 1; if (v < -half) v = -half; end
                2: begin v = ua + ub; if (v > m) v = m; end
                3: v = ua - ub;
                4: begin v = sa - sb2; if (v > half - 1) v = half - 1; if (v < -half) v = -half; end
                5: begin v = ua - ub; if (v < 0) v = 0; end
                6: v = (sa < sb2) ? ua : ub;
                7: v = (ua < ub) ? ua : ub;
                8: v = (sa > sb2) ? ua : ub;
                9: v = (ua > ub) ? ua : ub;
                10: v = (ua == ub) ? m : 0;
                11: v = (sa > sb2) ? m : 0;
                default: v = (ua > ub) ? m : 0;
            endcase
            r |= (64'(v & m)) << (i * lw);
        end
        return r;
    endfunction

    task automatic send(int o, int w, logic [63:0] x, logic [63:0] y, string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        op = 4'(o);
        width = 2'(w);
        a = x;
        b = y;
        it.exp = model(o, w, x, y);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(logic ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic longint unsigned next_rnd();
        rng ^= rng << 13;
        rng ^= rng >> 7;
        rng ^= rng << 17;
        return rng;
    endfunction

    // monitor: pops one expectation per valid output
    always @(posedge clk) begin
        #1;
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected valid", result, '0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(result == it.exp, it.tag, result, it.exp);
                last_exp = it.exp;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!out_valid && result == '0, "R1 reset state", result, '0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(!out_valid && result == '0, "R1 after release", {63'b0, out_valid}, '0);

        // R3 lane isolation with wrap: carries must not cross lanes
        send(0, 0, 64'h01FF_01FF_01FF_01FF, 64'h0001_0001_0001_0001, "R3 w8 add carry cut");
        send(0, 1, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, "R3 w16 add carry cut");
        send(0, 2, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, "R3 w32 add carry cut");
        send(3, 3, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, "R3 w3 as 32 borrow cut");
        send(3, 0, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, "R4 w8 sub wrap");
        // R5 signed clamp next to unclamped lanes
        send(1, 0, 64'h7F80_107F_0080_7F01, 64'h0180_1001_00FF_0101, "R5 w8 add sat mix");
        send(4, 1, 64'h8000_7FFF_0005_8001, 64'h0001_FFFF_0003_0001, "R5 w16 sub sat");
        send(1, 2, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, "R5 w32 add sat");
        // R6 unsigned clamp
        send(2, 0, 64'hFF10_F0FF_0102_8080, 64'h0110_20FF_0102_8080, "R6 w8 add usat");
        send(5, 1, 64'h0001_0005_FFFF_0000, 64'h0002_0003_0001_0001, "R6 w16 sub usat");
        // R7 min/max
        send(6, 0, 64'h80FF_017F_0000_0000, 64'h7F01_0280_0000_0001, "R7 w8 min signed");
        send(7, 0, 64'h80FF_017F_0000_0000, 64'h7F01_0280_0000_0001, "R7 w8 min unsigned");
        send(8, 1, 64'h8000_0001_7FFF_1234, 64'h7FFF_FFFF_8000_1234, "R7 w16 max signed");
        send(9, 2, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_0000_0002, "R7 w32 max unsigned");
        // R8 compares
        send(10, 0, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, "R8 w8 eq");
        send(11, 1, 64'h8000_0001_7FFF_0005, 64'h0001_8000_7FFF_0004, "R8 w16 gt signed");
        send(12, 0, 64'h80FF_0100_7F01_0203, 64'h7F00_0100_8002_0102, "R8 w8 gt unsigned");
        // R9 SAD, width ignored
        send(13, 2, 64'hFF00_FF00_FF00_FF00, 64'h00FF_00FF_00FF_00FF, "R9 sad max");
        send(13, 0, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, "R9 sad mixed");
        // R10 reserved
        send(14, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, "R10 op14");
        send(15, 1, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, "R10 op15");
        idle();
        // R2: idle cycles must not disturb the held result
        repeat (3) @(posedge clk);
        #1;
        check(!out_valid && result == last_exp, "R2 hold while idle", result, last_exp);
        // mixed back-to-back stream
        for (int k = 0; k < 150; k++) begin
            longint unsigned r0, r1, r2;
            r0 = next_rnd();
            r1 = next_rnd();
            r2 = next_rnd();
            send(int'(r2 & 15), int'((r2 >> 4) & 3), r0, r1, tag_of(int'(r2 & 15)));
            if ((r2 >> 8) % 5 == 0) idle();
        end
        idle();
        repeat (3) @(posedge clk);
        #1;
        check(sb.size() == 0, "R2 all results delivered", 64'(sb.size()), '0);
        check(!out_valid && result == last_exp, "R2 final hold", result, last_exp);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule